// File: doc/BRIEF.md
# Board Status and Parity Controller

This block gives host software a small bank of 16-bit registers for steering a network interface board and for seeing what went wrong on it. A status word drives the controls that leave the board: a hold-in-reset line for the network controller, an attention line, a line that takes the transceiver out of loopback, and an auxiliary memory bus enable. The same word carries two enables for the combined interrupt request. It also shows two read-only event flags and a set of board straps that are captured while the block is in reset.

The block watches two event sources. One is the network controller's interrupt line, which is brought into the clock domain through a synchronizer and shown as a flag. The other is a strobe from the board's memory parity checker. That strobe comes with the failing 20-bit address, the data half that failed and the agent that was driving the access. The first parity error is held, with its details, until the host acknowledges it through the parity control word. The details of later errors are dropped until that acknowledge arrives. The interrupt request combines both flags, each gated by its own enable.

Registers sit at word offsets 0 (status), 1 (parity control), 2 (low 16 bits of the captured parity address) and 3 (unused, reads zero). Reads are combinational from the offset. A write takes effect at the clock edge on which `hst_wr` is high.

Top module: `brd_stat_ctl`

## Requirements
- R1: Status bits 15, 14, 13, 12, 11 and 5 are read/write. Bit 15 drives `ctl_reset_o`, bit 14 drives `ctl_onair_o`, bit 13 drives `ctl_attn_o` and bit 5 drives `aux_bus_en_o`. Bit 12 is the controller-interrupt enable and bit 11 is the parity-interrupt enable. Each output reflects a status write from the cycle after the write edge.
- R2: Status bit 9 (parity flag) and bit 8 (interrupt flag) are read-only. Writes to status bits 10, 9, 8, 7, 6, 4 and 3..0 have no effect. Writes to offsets 2 and 3 have no effect, and offset 3 always reads 0.
- R3: Status bit 4 shows `ram_256k_i` and bits 3..0 show `ram_base_i`, both sampled on clock edges while `rst_n` is low. These bits do not change while `rst_n` stays high, whatever the strap inputs do.
- R4: The interrupt flag (status bit 8) follows `ctl_irq_i` with a delay of SYNC_STAGES+1 clock edges (3 by default).
- R5: A `par_err_i` strobe while no parity error is held sets status bit 9 from the next cycle. On that strobe the block captures the failing address, with bits 15..0 at offset 2 and bits 19..16 at parity control bits 3..0. It also captures `par_end_i` into parity control bit 6 and `par_src_i` into bit 7.
- R6: While a parity error is held, further strobes change neither the flag nor any captured field.
- R7: A write to offset 1 with bit 8 set clears the parity flag and leaves the captured fields as they are. If a strobe arrives in the same cycle, it is captured and the flag stays set. A write to offset 1 with bit 8 clear has no effect, and parity control bit 8 reads 0.
- R8: `irq_o` equals (interrupt flag AND status bit 12) OR (parity flag AND status bit 11).
- R9: While status bit 15 is set, `ctl_reset_o` is 1. From the following edge, both flags and all captured parity fields are held at 0, and parity strobes are ignored.
- R10: While `rst_n` is low, all writable status bits, both flags and all captured fields are 0.
- R11: Writing status bit 13 as 1 and then, in the next cycle, as 0 produces exactly one clock cycle of `ctl_attn_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the straps are sampled while it is low |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | 2 | Register word offset |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Read data for `hst_addr` (combinational) |
| ram_256k_i | input | 1 | Strap: board uses 256-kilobit RAM parts |
| ram_base_i | input | 4 | Strap: board RAM base, host address bits 19..16 |
| ctl_irq_i | input | 1 | Interrupt line from the network controller |
| par_err_i | input | 1 | One-cycle parity error strobe |
| par_addr_i | input | 20 | Failing address, valid with the strobe (PAR_ADDR_W) |
| par_end_i | input | 1 | Which data byte failed, valid with the strobe |
| par_src_i | input | 1 | Agent that drove the failing access, valid with the strobe |
| ctl_reset_o | output | 1 | Hold the network controller in reset |
| ctl_onair_o | output | 1 | Leave loopback |
| ctl_attn_o | output | 1 | Attention to the network controller |
| aux_bus_en_o | output | 1 | Auxiliary memory bus enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Directed cases come first, each one separating behaviours that the random traffic rarely lines up:
- An all-ones status write separates the writable bits from the read-only ones.
- A set-then-clear attention pair measures the pulse width.
- A single rising interrupt edge fixes the synchronizer latency.
- A sequence of parity cases separates first-error capture from overwrite: a second strobe while the error is held, an acknowledge with bit 8 clear, a real acknowledge, and an acknowledge that coincides with a new strobe.

A board-reset write that overlaps a strobe shows whether the flags are forced clear. Seeded random traffic then mixes status and parity-control writes, dead-offset writes, strap changes, interrupt toggles and parity strobes. This exposes interactions between the enables, the acknowledge and board reset that the fixed cases do not reach.

// File: rtl/brd_stat_pkg.sv
package brd_stat_pkg;

   localparam int REG_W    = 16;
   localparam int PLO_W    = 16;
   localparam int STRAP_W  = 5;

   // register word offsets
   localparam logic [1:0] OFS_STAT = 2'd0;
   localparam logic [1:0] OFS_PCTL = 2'd1;
   localparam logic [1:0] OFS_PADR = 2'd2;

   // status word bit positions (software decodes these)
   localparam int B_BRST  = 15;
   localparam int B_ONAIR = 14;
   localparam int B_ATTN  = 13;
   localparam int B_IEN   = 12;
   localparam int B_PIEN  = 11;
   localparam int B_PFLG  = 9;
   localparam int B_IFLG  = 8;
   localparam int B_AUX   = 5;
   localparam int B_R256  = 4;

   // parity control bit positions
   localparam int B_PACK  = 8;
   localparam int B_PSRC  = 7;
   localparam int B_PEND  = 6;

   typedef struct packed {
      logic brst;
      logic onair;
      logic attn;
      logic ien;
      logic pien;
      logic aux;
   } stat_ctl_t;

   typedef struct packed {
      logic       r256;
      logic [3:0] base;
   } strap_t;

endpackage

// File: rtl/brd_irq_sync.sv
module brd_irq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= d_i;
         end
         assign q_o = q;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-2:0], d_i};
         end
         assign q_o = sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/brd_ctl_reg.sv
module brd_ctl_reg
   import brd_stat_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_i,
   input  stat_ctl_t wval_i,
   input  strap_t    strap_i,
   output stat_ctl_t ctl_o,
   output strap_t    strap_o
);

   stat_ctl_t ctl_q;
   strap_t    strap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ctl_q <= '0;
      else if (wr_i) ctl_q <= wval_i;
   end

   // straps load only while reset is held; no reset value of their own
   always_ff @(posedge clk) begin
      if (!rst_n) strap_q <= strap_i;
   end

   assign ctl_o   = ctl_q;
   assign strap_o = strap_q;

endmodule

// File: rtl/brd_par_capture.sv
module brd_par_capture
   import brd_stat_pkg::*;
#(
   parameter int ADDR_W = 20,
   localparam int HI_W  = ADDR_W - PLO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              ack_i,
   input  logic              err_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              end_i,
   input  logic              src_i,
   output logic              flag_o,
   output logic [PLO_W-1:0]  addr_lo_o,
   output logic [HI_W-1:0]   addr_hi_o,
   output logic              end_o,
   output logic              src_o
);

   logic              flag_q;
   logic [ADDR_W-1:0] addr_q;
   logic              end_q;
   logic              src_q;
   logic              take;

   // a new error is taken when nothing is held or the held one is being released
   assign take = err_i && (!flag_q || ack_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         addr_q <= '0;
         end_q  <= 1'b0;
         src_q  <= 1'b0;
      end else if (clr_i) begin
         flag_q <= 1'b0;
         addr_q <= '0;
         end_q  <= 1'b0;
         src_q  <= 1'b0;
      end else if (take) begin
         flag_q <= 1'b1;
         addr_q <= addr_i;
         end_q  <= end_i;
         src_q  <= src_i;
      end else if (ack_i) begin
         flag_q <= 1'b0;
      end
   end

   assign flag_o    = flag_q;
   assign addr_lo_o = addr_q[PLO_W-1:0];
   assign addr_hi_o = addr_q[ADDR_W-1:PLO_W];
   assign end_o     = end_q;
   assign src_o     = src_q;

endmodule

// File: rtl/brd_stat_ctl.sv
module brd_stat_ctl
   import brd_stat_pkg::*;
#(
   parameter int PAR_ADDR_W  = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hst_wr,
   input  logic [1:0]            hst_addr,
   input  logic [REG_W-1:0]      hst_wdata,
   output logic [REG_W-1:0]      hst_rdata,
   input  logic                  ram_256k_i,
   input  logic [3:0]            ram_base_i,
   input  logic                  ctl_irq_i,
   input  logic                  par_err_i,
   input  logic [PAR_ADDR_W-1:0] par_addr_i,
   input  logic                  par_end_i,
   input  logic                  par_src_i,
   output logic                  ctl_reset_o,
   output logic                  ctl_onair_o,
   output logic                  ctl_attn_o,
   output logic                  aux_bus_en_o,
   output logic                  irq_o
);

   localparam int HI_W = PAR_ADDR_W - PLO_W;

   generate
      if (PAR_ADDR_W < PLO_W + 1 || PAR_ADDR_W > PLO_W + 4) begin : g_bad_aw
         $error("PAR_ADDR_W must leave 1..4 high bits for the parity control word");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be in 1..4");
      end
   endgenerate

   // write decode
   logic      wr_stat, wr_ack;
   stat_ctl_t wval;
   assign wr_stat = hst_wr && (hst_addr == OFS_STAT);
   assign wr_ack  = hst_wr && (hst_addr == OFS_PCTL) && hst_wdata[B_PACK];

   always_comb begin
      wval.brst  = hst_wdata[B_BRST];
      wval.onair = hst_wdata[B_ONAIR];
      wval.attn  = hst_wdata[B_ATTN];
      wval.ien   = hst_wdata[B_IEN];
      wval.pien  = hst_wdata[B_PIEN];
      wval.aux   = hst_wdata[B_AUX];
   end

   logic wire_unused;
   assign wire_unused = ^{hst_wdata[10:9], hst_wdata[7:6], hst_wdata[4:0]};

   stat_ctl_t ctl;
   strap_t    strap;

   brd_ctl_reg u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_stat),
      .wval_i  (wval),
      .strap_i ({ram_256k_i, ram_base_i}),
      .ctl_o   (ctl),
      .strap_o (strap)
   );

   // controller interrupt: synchronizer then flag
   logic irq_sync, iflag_q;

   brd_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ctl_irq_i),
      .q_o   (irq_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        iflag_q <= 1'b0;
      else if (ctl.brst) iflag_q <= 1'b0;
      else               iflag_q <= irq_sync;
   end

   // parity error capture
   logic              pflag;
   logic [PLO_W-1:0]  paddr_lo;
   logic [HI_W-1:0]   paddr_hi;
   logic              pend, psrc;

   brd_par_capture #(.ADDR_W(PAR_ADDR_W)) u_par (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (ctl.brst),
      .ack_i     (wr_ack),
      .err_i     (par_err_i),
      .addr_i    (par_addr_i),
      .end_i     (par_end_i),
      .src_i     (par_src_i),
      .flag_o    (pflag),
      .addr_lo_o (paddr_lo),
      .addr_hi_o (paddr_hi),
      .end_o     (pend),
      .src_o     (psrc)
   );

   // register images
   logic [REG_W-1:0] stat_rd, pctl_rd, palo_rd;

   always_comb begin
      stat_rd           = '0;
      stat_rd[B_BRST]   = ctl.brst;
      stat_rd[B_ONAIR]  = ctl.onair;
      stat_rd[B_ATTN]   = ctl.attn;
      stat_rd[B_IEN]    = ctl.ien;
      stat_rd[B_PIEN]   = ctl.pien;
      stat_rd[B_PFLG]   = pflag;
      stat_rd[B_IFLG]   = iflag_q;
      stat_rd[B_AUX]    = ctl.aux;
      stat_rd[B_R256]   = strap.r256;
      stat_rd[3:0]      = strap.base;
   end

   always_comb begin
      pctl_rd           = '0;
      pctl_rd[B_PSRC]   = psrc;
      pctl_rd[B_PEND]   = pend;
      pctl_rd[HI_W-1:0] = paddr_hi;
   end

   assign palo_rd = paddr_lo;

   always_comb begin
      case (hst_addr)
         OFS_STAT: hst_rdata = stat_rd;
         OFS_PCTL: hst_rdata = pctl_rd;
         OFS_PADR: hst_rdata = palo_rd;
         default:  hst_rdata = '0;
      endcase
   end

   assign ctl_reset_o  = ctl.brst;
   assign ctl_onair_o  = ctl.onair;
   assign ctl_attn_o   = ctl.attn;
   assign aux_bus_en_o = ctl.aux;
   assign irq_o        = (iflag_q && ctl.ien) || (pflag && ctl.pien);

endmodule

// File: rtl/brd_stat_ctl_chk.sv
module brd_stat_ctl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        hst_wr,
   input logic [1:0]  hst_addr,
   input logic        wd_brst,
   input logic        wd_attn,
   input logic        wd_ack,
   input logic        par_err_i,
   input logic        ctl_reset_o,
   input logic        ctl_attn_o,
   input logic        irq_o,
   input logic [15:0] stat_rd,
   input logic [15:0] pctl_rd,
   input logic [15:0] palo_rd
);

   logic ack, swr;
   assign ack = hst_wr && (hst_addr == 2'd1) && wd_ack;
   assign swr = hst_wr && (hst_addr == 2'd0);

   logic unused_stat;
   assign unused_stat = ^{stat_rd[15:13], stat_rd[10], stat_rd[7:5]};

   p_ctl_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      swr |=> (ctl_attn_o == $past(wd_attn)) && (ctl_reset_o == $past(wd_brst)));

   p_strap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(stat_rd[4:0]));

   p_par_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (par_err_i && !ctl_reset_o) |=> stat_rd[9]);

   p_par_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd[9] && !ack && !ctl_reset_o)
      |=> stat_rd[9] && $stable(palo_rd) && $stable(pctl_rd));

   p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd[9] && ack && !par_err_i && !ctl_reset_o) |=> !stat_rd[9]);

   p_irq_comb_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == ((stat_rd[8] && stat_rd[12]) || (stat_rd[9] && stat_rd[11])));

   p_brst_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_reset_o |=> !stat_rd[9] && !stat_rd[8] && (palo_rd == 16'h0));

endmodule

bind brd_stat_ctl brd_stat_ctl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .hst_wr      (hst_wr),
   .hst_addr    (hst_addr),
   .wd_brst     (hst_wdata[15]),
   .wd_attn     (hst_wdata[13]),
   .wd_ack      (hst_wdata[8]),
   .par_err_i   (par_err_i),
   .ctl_reset_o (ctl_reset_o),
   .ctl_attn_o  (ctl_attn_o),
   .irq_o       (irq_o),
   .stat_rd     (stat_rd),
   .pctl_rd     (pctl_rd),
   .palo_rd     (palo_rd)
);

// File: tb/brd_stat_ctl_tb_top.sv
`timescale 1ns/1ps
module brd_stat_ctl_tb_top;

   localparam int AW   = 20;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          hst_wr = 1'b0;
   logic [1:0]    hst_addr = 2'd0;
   logic [15:0]   hst_wdata = '0;
   logic [15:0]   hst_rdata;
   logic          ram_256k_i = 1'b1;
   logic [3:0]    ram_base_i = 4'hA;
   logic          ctl_irq_i = 1'b0;
   logic          par_err_i = 1'b0;
   logic [AW-1:0] par_addr_i = '0;
   logic          par_end_i = 1'b0;
   logic          par_src_i = 1'b0;
   logic          ctl_reset_o, ctl_onair_o, ctl_attn_o, aux_bus_en_o, irq_o;

   brd_stat_ctl #(.PAR_ADDR_W(AW), .SYNC_STAGES(SYNC)) dut_i (.*);

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // requirement-level model, updated at each rising edge
   logic          m_brst, m_onair, m_attn, m_ien, m_pien, m_aux;
   logic [4:0]    m_strap;
   logic          m_pf, m_if, m_end, m_src;
   logic [AW-1:0] m_addr;
   logic [SYNC-1:0] m_sp;
   logic          m_ack, m_sw, m_nif;

   always @(posedge clk) begin
      if (!rst_n) begin
         {m_brst, m_onair, m_attn, m_ien, m_pien, m_aux} = '0;
         m_strap = {ram_256k_i, ram_base_i};
         m_pf = 0; m_if = 0; m_end = 0; m_src = 0; m_addr = '0; m_sp = '0;
      end else begin
         m_ack = hst_wr && hst_addr == 2'd1 && hst_wdata[8];
         m_sw  = hst_wr && hst_addr == 2'd0;
         m_nif = m_brst ? 1'b0 : m_sp[SYNC-1];
         m_sp  = {m_sp[SYNC-2:0], ctl_irq_i};
         m_if  = m_nif;
         if (m_brst) begin
            m_pf = 0; m_addr = '0; m_end = 0; m_src = 0;
         end else if (par_err_i && (!m_pf || m_ack)) begin
            m_pf = 1; m_addr = par_addr_i; m_end = par_end_i; m_src = par_src_i;
         end else if (m_ack) begin
            m_pf = 0;
         end
         if (m_sw) begin
            m_brst  = hst_wdata[15]; m_onair = hst_wdata[14]; m_attn = hst_wdata[13];
            m_ien   = hst_wdata[12]; m_pien  = hst_wdata[11]; m_aux  = hst_wdata[5];
         end
      end
   end

   function automatic logic [15:0] exp_stat();
      return {m_brst, m_onair, m_attn, m_ien, m_pien, 1'b0, m_pf, m_if, 2'b00, m_aux, m_strap};
   endfunction
   function automatic logic [15:0] exp_pctl();
      return {8'h00, m_src, m_end, 2'b00, m_addr[19:16]};
   endfunction
   function automatic logic exp_irq();
      return (m_if && m_ien) || (m_pf && m_pien);
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s act=0x%04h exp=0x%04h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      hst_addr = a;
      #1;
      d = hst_rdata;
   endtask

   task automatic cmp_all();
      logic [15:0] d;
      rd(2'd0, d); chk(d === exp_stat(), "R2", "status word", d, exp_stat());
      rd(2'd1, d); chk(d === exp_pctl(), "R5", "parity control", d, exp_pctl());
      rd(2'd2, d); chk(d === m_addr[15:0], "R5", "parity addr low", d, m_addr[15:0]);
      rd(2'd3, d); chk(d === 16'h0, "R2", "offset 3", d, 16'h0);
      chk(irq_o === exp_irq(), "R8", "irq_o", {15'h0, irq_o}, {15'h0, exp_irq()});
      chk({ctl_reset_o, ctl_onair_o, ctl_attn_o, aux_bus_en_o} ===
          {m_brst, m_onair, m_attn, m_aux}, "R1", "control outputs",
          {12'h0, ctl_reset_o, ctl_onair_o, ctl_attn_o, aux_bus_en_o},
          {12'h0, m_brst, m_onair, m_attn, m_aux});
   endtask

   task automatic step(input logic w, input logic [1:0] a, input logic [15:0] d,
                       input logic pe, input logic [AW-1:0] pa,
                       input logic pend, input logic psrc);
      hst_wr = w; hst_addr = a; hst_wdata = d;
      par_err_i = pe; par_addr_i = pa; par_end_i = pend; par_src_i = psrc;
      @(posedge clk);
      @(negedge clk);
      hst_wr = 1'b0; par_err_i = 1'b0;
      cmp_all();
   endtask

   task automatic idle();
      step(1'b0, 2'd0, 16'h0, 1'b0, '0, 1'b0, 1'b0);
   endtask

   task automatic wstat(input logic [15:0] d);
      step(1'b1, 2'd0, d, 1'b0, '0, 1'b0, 1'b0);
   endtask

   task automatic wpctl(input logic [15:0] d);
      step(1'b1, 2'd1, d, 1'b0, '0, 1'b0, 1'b0);
   endtask

   task automatic perr(input logic [AW-1:0] pa, input logic pend, input logic psrc);
      step(1'b0, 2'd0, 16'h0, 1'b1, pa, pend, psrc);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements) act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      void'($urandom(32'd1357));

      // R10 / R3: reset state with straps 1,0xA
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      rd(2'd0, d); chk(d === 16'h001A, "R10", "status after reset", d, 16'h001A);
      rd(2'd1, d); chk(d === 16'h0000, "R10", "pctl after reset", d, 16'h0000);
      rd(2'd2, d); chk(d === 16'h0000, "R10", "paddr after reset", d, 16'h0000);
      chk({ctl_reset_o, ctl_attn_o, ctl_onair_o, aux_bus_en_o, irq_o} === 5'b0, "R10",
          "outputs after reset", {11'h0, ctl_reset_o, ctl_attn_o, ctl_onair_o, aux_bus_en_o, irq_o}, 16'h0);

      // R3: strap changes after reset are not seen
      ram_256k_i = 1'b0; ram_base_i = 4'h5;
      idle();
      rd(2'd0, d); chk(d[4:0] === 5'h1A, "R3", "straps held", {11'h0, d[4:0]}, 16'h001A);

      // R1 / R2: writable bits only
      wstat(16'h5FFF);
      rd(2'd0, d); chk(d === 16'h583A, "R2", "read-only bits kept", d, 16'h583A);
      chk(ctl_onair_o === 1'b1 && aux_bus_en_o === 1'b1 && ctl_reset_o === 1'b0, "R1",
          "onair/aux driven", {13'h0, ctl_onair_o, aux_bus_en_o, ctl_reset_o}, 16'h0006);
      step(1'b1, 2'd2, 16'hFFFF, 1'b0, '0, 1'b0, 1'b0);
      step(1'b1, 2'd3, 16'hFFFF, 1'b0, '0, 1'b0, 1'b0);
      rd(2'd2, d); chk(d === 16'h0000, "R2", "offset 2 not writable", d, 16'h0000);

      // R11: one attention pulse
      wstat(16'h7820);
      chk(ctl_attn_o === 1'b1, "R11", "attn high", {15'h0, ctl_attn_o}, 16'h1);
      wstat(16'h5820);
      chk(ctl_attn_o === 1'b0, "R11", "attn low after one cycle", {15'h0, ctl_attn_o}, 16'h0);

      // R4: interrupt latency SYNC+1 edges
      ctl_irq_i = 1'b1;
      idle();
      rd(2'd0, d); chk(d[8] === 1'b0, "R4", "iflag edge1", {15'h0, d[8]}, 16'h0);
      idle();
      rd(2'd0, d); chk(d[8] === 1'b0, "R4", "iflag edge2", {15'h0, d[8]}, 16'h0);
      idle();
      rd(2'd0, d); chk(d[8] === 1'b1, "R4", "iflag edge3", {15'h0, d[8]}, 16'h1);
      chk(irq_o === 1'b1, "R8", "irq from iflag", {15'h0, irq_o}, 16'h1);
      wstat(16'h4820);
      chk(irq_o === 1'b0, "R8", "irq masked by bit 12", {15'h0, irq_o}, 16'h0);
      ctl_irq_i = 1'b0;
      repeat (4) idle();

      // R5: first capture
      perr(20'hABCDE, 1'b1, 1'b0);
      rd(2'd1, d); chk(d === 16'h004A, "R5", "pctl capture", d, 16'h004A);
      rd(2'd2, d); chk(d === 16'hBCDE, "R5", "paddr capture", d, 16'hBCDE);
      chk(irq_o === 1'b1, "R8", "irq from pflag", {15'h0, irq_o}, 16'h1);

      // R6: second error ignored
      perr(20'h12345, 1'b0, 1'b1);
      rd(2'd2, d); chk(d === 16'hBCDE, "R6", "paddr kept", d, 16'hBCDE);

      // R7: acknowledge behaviour
      wpctl(16'h00FF);
      rd(2'd0, d); chk(d[9] === 1'b1, "R7", "bit8 clear no ack", {15'h0, d[9]}, 16'h1);
      wpctl(16'h0100);
      rd(2'd0, d); chk(d[9] === 1'b0, "R7", "ack clears flag", {15'h0, d[9]}, 16'h0);
      rd(2'd2, d); chk(d === 16'hBCDE, "R7", "fields kept after ack", d, 16'hBCDE);
      perr(20'h12345, 1'b0, 1'b1);
      rd(2'd1, d); chk(d === 16'h0081, "R5", "second capture pctl", d, 16'h0081);
      step(1'b1, 2'd1, 16'h0100, 1'b1, 20'h6789A, 1'b1, 1'b1);
      rd(2'd1, d); chk(d === 16'h00C6, "R7", "ack+strobe captured", d, 16'h00C6);
      rd(2'd0, d); chk(d[9] === 1'b1, "R7", "ack+strobe flag set", {15'h0, d[9]}, 16'h1);

      // R9: board reset clears and blocks
      wstat(16'hD820);
      chk(ctl_reset_o === 1'b1, "R9", "reset output", {15'h0, ctl_reset_o}, 16'h1);
      perr(20'hFFFFF, 1'b1, 1'b1);
      rd(2'd0, d); chk(d[9:8] === 2'b00, "R9", "flags cleared", {14'h0, d[9:8]}, 16'h0);
      rd(2'd2, d); chk(d === 16'h0000, "R9", "paddr cleared", d, 16'h0000);
      rd(2'd1, d); chk(d === 16'h0000, "R9", "pctl cleared", d, 16'h0000);
      wstat(16'h5820);

      // random phase
      for (int i = 0; i < 3000; i++) begin
         int unsigned r;
         logic [15:0] wd;
         r  = $urandom_range(0, 99);
         wd = 16'($urandom);
         if ($urandom_range(0, 9) != 0) wd[15] = 1'b0;
         if ($urandom_range(0, 19) == 0) ram_base_i = 4'($urandom);
         if ($urandom_range(0, 9) == 0) ctl_irq_i = ~ctl_irq_i;
         step(r < 40, (r < 25) ? 2'd0 : (r < 35) ? 2'd1 : 2'($urandom_range(2, 3)),
              wd, $urandom_range(0, 4) == 0, AW'($urandom),
              1'($urandom), 1'($urandom));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule